// File: doc/BRIEF.md
# Conversion Trigger Source Selector

This block sits in front of an analogue-to-digital conversion controller. It decides when a new conversion should start. It watches eight event lines and picks one of them with a 3-bit source code. When automatic triggering is enabled, a rising edge on the picked line produces a one-cycle start request. The eight lines are the converter's own end-of-conversion pulse, a comparator output, an external interrupt line, two compare-match events and an overflow from a first timer, and an overflow and a capture event from a second timer.

When code 000 is chosen, the end-of-conversion pulse is the trigger, so the converter restarts itself after every result. A manual start pulse begins the first conversion of such a run, and it also serves single conversions when automatic triggering is off. All edge detection runs in the system clock domain. Requests are dropped, not held back, while the converter is disabled or busy. A change of source code clears the edge history, so a line that is already high on the newly selected source does not count as an edge.

Top module: `adc_trig_select`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `start_req` is 0. A source or manual line that is already high when reset is released does not produce a request until it has been seen low.
- R2: Source codes pick the lines as follows: 000 `conv_done`, 001 `cmp_out`, 010 `ext_irq`, 011 `t0_cmp_a`, 100 `t0_ovf`, 101 `t0_cmp_b`, 110 `t1_ovf`, 111 `t1_capt`. Lines that are not selected have no effect on `start_req`.
- R3: Suppose `auto_en`, `conv_enable` and the not-busy state hold, and the source code is unchanged. If the selected line is sampled low in one cycle and high in the next, `start_req` is 1 in the cycle after the high sample.
- R4: With `auto_en` at 0, edges on the selected line never raise `start_req`.
- R5: Under code 000 with `auto_en` at 1, each rising edge of `conv_done` requests the next conversion, so the converter runs continuously once started.
- R6: A rising edge of `manual_start` raises `start_req` one cycle later, whatever the value of `auto_en`, while the converter is enabled and idle.
- R7: An edge that arrives while `conv_busy` is 1 is dropped and is not issued later.
- R8: In the cycle the source code changes, no trigger edge is seen. A new source that is already high produces no request. A new source that is low and then rises produces a request as in R3.
- R9: `start_req` is never 1 in two consecutive cycles.
- R10: While `conv_enable` is 0, no request is produced, and an edge seen in that time is not issued after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_enable | input | 1 | Converter powered and enabled |
| auto_en | input | 1 | Automatic triggering enable |
| src_sel | input | 3 | Trigger source code |
| manual_start | input | 1 | Software start, rising edge acts |
| conv_busy | input | 1 | Conversion in progress |
| conv_done | input | 1 | End-of-conversion pulse (free-running source) |
| cmp_out | input | 1 | Comparator output |
| ext_irq | input | 1 | External interrupt line |
| t0_cmp_a | input | 1 | First timer, compare match A |
| t0_ovf | input | 1 | First timer, overflow |
| t0_cmp_b | input | 1 | First timer, compare match B |
| t1_ovf | input | 1 | Second timer, overflow |
| t1_capt | input | 1 | Second timer, capture event |
| start_req | output | 1 | Registered one-cycle start request |

## Verification
The hardest situation to reach from the ports is the self-sustaining free-running loop. There, `conv_done` has to come back as a rising edge at the moment `conv_busy` has just dropped. The bench reaches it with a small behavioural converter that answers each `start_req` with a busy window followed by a done pulse. It then counts how many restarts happen with no further manual start. A second awkward case is a source switch onto a line that is already high. Directed steps hold every event line high, switch codes, and then lower and raise only the new line. Random stimulus then mixes busy, disable and code changes against a cycle model of the requirements.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
  localparam int SRC_SEL_W = 3;
  localparam int SRC_COUNT = 1 << SRC_SEL_W;

  // Code order matters: it is the source decode seen by software.
  typedef enum logic [SRC_SEL_W-1:0] {
    TRG_FREE_RUN = 3'd0,
    TRG_CMP      = 3'd1,
    TRG_EXT_IRQ  = 3'd2,
    TRG_T0_CMPA  = 3'd3,
    TRG_T0_OVF   = 3'd4,
    TRG_T0_CMPB  = 3'd5,
    TRG_T1_OVF   = 3'd6,
    TRG_T1_CAPT  = 3'd7
  } trig_src_e;
endpackage

// File: rtl/trig_src_mux.sv
module trig_src_mux #(
  parameter int SEL_W = 3,
  localparam int NSRC = 1 << SEL_W
) (
  input  logic [NSRC-1:0]  src_vec,
  input  logic [SEL_W-1:0] sel,
  output logic             level
);
  logic [NSRC-1:0] tap;

  // One-hot AND-OR select: a shallow tree instead of a priority chain.
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_tap
      assign tap[i] = src_vec[i] & (sel == SEL_W'(i));
    end
  endgenerate

  assign level = |tap;
endmodule

// File: rtl/trig_edge_det.sv
module trig_edge_det #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  input  logic             level,
  input  logic             man_level,
  output logic             trig_edge,
  output logic             man_edge
);
  logic [SEL_W-1:0] sel_q;
  logic             hist_q;
  logic             man_q;
  logic             sel_same;

  assign sel_same  = (sel == sel_q);
  assign trig_edge = level & ~hist_q & sel_same;
  assign man_edge  = man_level & ~man_q;

  // History starts high so a line already asserted at reset gives no edge.
  // It also reloads from the new source when the code changes.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      hist_q <= 1'b1;
      man_q  <= 1'b1;
    end else begin
      sel_q  <= sel;
      hist_q <= level;
      man_q  <= man_level;
    end
  end
endmodule

// File: rtl/trig_req_gen.sv
module trig_req_gen (
  input  logic clk,
  input  logic rst,
  input  logic conv_enable,
  input  logic conv_busy,
  input  logic auto_en,
  input  logic trig_edge,
  input  logic man_edge,
  output logic start_req
);
  logic want;

  assign want = man_edge | (auto_en & trig_edge);

  // Edges are dropped, not queued, when the converter cannot take them.
  always_ff @(posedge clk) begin
    if (rst) start_req <= 1'b0;
    else     start_req <= want & conv_enable & ~conv_busy & ~start_req;
  end
endmodule

// File: rtl/adc_trig_select.sv
module adc_trig_select
  import adc_trig_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 conv_enable,
  input  logic                 auto_en,
  input  logic [SRC_SEL_W-1:0] src_sel,
  input  logic                 manual_start,
  input  logic                 conv_busy,
  input  logic                 conv_done,
  input  logic                 cmp_out,
  input  logic                 ext_irq,
  input  logic                 t0_cmp_a,
  input  logic                 t0_ovf,
  input  logic                 t0_cmp_b,
  input  logic                 t1_ovf,
  input  logic                 t1_capt,
  output logic                 start_req
);
  logic [SRC_COUNT-1:0] src_vec;
  logic                 sel_level;
  logic                 trig_edge;
  logic                 man_edge;

  always_comb begin
    src_vec               = '0;
    src_vec[TRG_FREE_RUN] = conv_done;
    src_vec[TRG_CMP]      = cmp_out;
    src_vec[TRG_EXT_IRQ]  = ext_irq;
    src_vec[TRG_T0_CMPA]  = t0_cmp_a;
    src_vec[TRG_T0_OVF]   = t0_ovf;
    src_vec[TRG_T0_CMPB]  = t0_cmp_b;
    src_vec[TRG_T1_OVF]   = t1_ovf;
    src_vec[TRG_T1_CAPT]  = t1_capt;
  end

  trig_src_mux #(.SEL_W(SRC_SEL_W)) u_mux (
    .src_vec (src_vec),
    .sel     (src_sel),
    .level   (sel_level)
  );

  trig_edge_det #(.SEL_W(SRC_SEL_W)) u_edge (
    .clk       (clk),
    .rst       (rst),
    .sel       (src_sel),
    .level     (sel_level),
    .man_level (manual_start),
    .trig_edge (trig_edge),
    .man_edge  (man_edge)
  );

  trig_req_gen u_req (
    .clk         (clk),
    .rst         (rst),
    .conv_enable (conv_enable),
    .conv_busy   (conv_busy),
    .auto_en     (auto_en),
    .trig_edge   (trig_edge),
    .man_edge    (man_edge),
    .start_req   (start_req)
  );
endmodule

// File: rtl/adc_trig_select_chk.sv
module adc_trig_select_chk (
  input logic       clk,
  input logic       rst,
  input logic       conv_enable,
  input logic       auto_en,
  input logic [2:0] src_sel,
  input logic       manual_start,
  input logic       conv_busy,
  input logic       conv_done,
  input logic       cmp_out,
  input logic       start_req
);
  // Set from the second cycle after reset so that $past covers real history.
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) rst |=> !start_req);

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    start_req |=> !start_req);

  assert_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    !conv_enable |=> !start_req);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (rst)
    conv_busy |=> !start_req);

  assert_auto_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!auto_en && !manual_start) |=> !start_req);

  assert_src_change_R8: assert property (@(posedge clk) disable iff (rst)
    (armed && (src_sel != $past(src_sel)) && !manual_start) |=> !start_req);

  assert_cmp_edge_R3: assert property (@(posedge clk) disable iff (rst)
    (armed && auto_en && conv_enable && !conv_busy && !start_req &&
     src_sel == 3'd1 && $past(src_sel) == 3'd1 &&
     cmp_out && !$past(cmp_out)) |=> start_req);

  assert_free_run_R5: assert property (@(posedge clk) disable iff (rst)
    (armed && auto_en && conv_enable && !conv_busy && !start_req &&
     src_sel == 3'd0 && $past(src_sel) == 3'd0 &&
     conv_done && !$past(conv_done)) |=> start_req);
endmodule

bind adc_trig_select adc_trig_select_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .conv_enable  (conv_enable),
  .auto_en      (auto_en),
  .src_sel      (src_sel),
  .manual_start (manual_start),
  .conv_busy    (conv_busy),
  .conv_done    (conv_done),
  .cmp_out      (cmp_out),
  .start_req    (start_req)
);

// File: tb/test_adc_trig_select.sv
module test_adc_trig_select;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       conv_enable = 1'b0, auto_en = 1'b0, manual_start = 1'b0;
  logic [2:0] src_sel = 3'd0;
  logic       conv_busy = 1'b0, conv_done = 1'b0, cmp_out = 1'b0, ext_irq = 1'b0;
  logic       t0_cmp_a = 1'b0, t0_ovf = 1'b0, t0_cmp_b = 1'b0, t1_ovf = 1'b0, t1_capt = 1'b0;
  logic       start_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench model state
  logic [2:0] m_src = 3'd0;
  logic       m_hist = 1'b1, m_man = 1'b1, m_req = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_trig_select i_adc_trig_select (
    .clk(clk), .rst(rst), .conv_enable(conv_enable), .auto_en(auto_en),
    .src_sel(src_sel), .manual_start(manual_start), .conv_busy(conv_busy),
    .conv_done(conv_done), .cmp_out(cmp_out), .ext_irq(ext_irq),
    .t0_cmp_a(t0_cmp_a), .t0_ovf(t0_ovf), .t0_cmp_b(t0_cmp_b),
    .t1_ovf(t1_ovf), .t1_capt(t1_capt), .start_req(start_req)
  );

  // R2 code map as stated in the requirements
  function automatic logic src_level(input logic [2:0] code);
    case (code)
      3'd0: return conv_done;
      3'd1: return cmp_out;
      3'd2: return ext_irq;
      3'd3: return t0_cmp_a;
      3'd4: return t0_ovf;
      3'd5: return t0_cmp_b;
      3'd6: return t1_ovf;
      default: return t1_capt;
    endcase
  endfunction

  function automatic logic next_req();
    logic lvl, tedge, medge;
    lvl   = src_level(src_sel);
    tedge = lvl && !m_hist && (src_sel == m_src);
    medge = manual_start && !m_man;
    return !rst && conv_enable && !conv_busy && !m_req && (medge || (auto_en && tedge));
  endfunction

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: start_req actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: model the edge from current inputs, then check after it.
  task automatic tick(input string tag);
    logic exp;
    exp = next_req();
    if (rst) begin
      m_src = 3'd0; m_hist = 1'b1; m_man = 1'b1;
    end else begin
      m_hist = src_level(src_sel); m_src = src_sel; m_man = manual_start;
    end
    m_req = exp;
    @(negedge clk);
    check(tag, start_req, exp);
  endtask

  task automatic all_src(input logic v);
    conv_done = v; cmp_out = v; ext_irq = v; t0_cmp_a = v;
    t0_ovf = v; t0_cmp_b = v; t1_ovf = v; t1_capt = v;
  endtask

  task automatic set_src(input logic [2:0] code, input logic v);
    case (code)
      3'd0: conv_done = v;
      3'd1: cmp_out = v;
      3'd2: ext_irq = v;
      3'd3: t0_cmp_a = v;
      3'd4: t0_ovf = v;
      3'd5: t0_cmp_b = v;
      3'd6: t1_ovf = v;
      default: t1_capt = v;
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int nreq;
    int cnt;
    logic done_pend;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);

    // R1: reset with sources and manual start already high
    rst = 1'b1; conv_enable = 1'b1; auto_en = 1'b1; src_sel = 3'd1;
    cmp_out = 1'b1; manual_start = 1'b1;
    tick("R1"); tick("R1");
    rst = 1'b0;
    tick("R1"); tick("R1"); tick("R1");
    cmp_out = 1'b0; manual_start = 1'b0;
    tick("R1");

    // R3 on the comparator source, then R2 on every code
    cmp_out = 1'b1; tick("R3");
    if (start_req !== 1'b1) check("R3", start_req, 1'b1);
    tick("R9");
    cmp_out = 1'b0; tick("R3");
    for (int s = 0; s < 8; s++) begin
      src_sel = 3'(s); all_src(1'b0);
      tick("R2"); tick("R2");
      all_src(1'b1); set_src(3'(s), 1'b0); tick("R2");
      all_src(1'b0); tick("R2");
      set_src(3'(s), 1'b1); tick("R2");
      check("R2", start_req, 1'b1);
      set_src(3'(s), 1'b0); tick("R2");
    end

    // R4: auto trigger off
    auto_en = 1'b0; src_sel = 3'd2;
    tick("R4");
    for (int k = 0; k < 4; k++) begin
      ext_irq = 1'b1; tick("R4"); ext_irq = 1'b0; tick("R4");
    end
    // R6: manual start without auto trigger
    manual_start = 1'b1; tick("R6"); check("R6", start_req, 1'b1);
    tick("R6"); manual_start = 1'b0; tick("R6");
    auto_en = 1'b1;

    // R7: edge during busy is dropped
    conv_busy = 1'b1; ext_irq = 1'b1; tick("R7"); tick("R7");
    conv_busy = 1'b0; tick("R7"); tick("R7");
    ext_irq = 1'b0; tick("R7");

    // R10: edge while disabled is not issued later
    conv_enable = 1'b0; ext_irq = 1'b1; tick("R10");
    conv_enable = 1'b1; tick("R10"); tick("R10");
    ext_irq = 1'b0; tick("R10");

    // R8: switch onto a source already high
    t1_ovf = 1'b1; tick("R8");
    src_sel = 3'd6; tick("R8"); tick("R8");
    t1_ovf = 1'b0; tick("R8");
    t1_ovf = 1'b1; tick("R8"); check("R8", start_req, 1'b1);
    // switch to a low source that rises right after the change
    src_sel = 3'd4; t0_ovf = 1'b0; tick("R8");
    t0_ovf = 1'b1; tick("R8"); check("R8", start_req, 1'b1);
    all_src(1'b0); tick("R8");

    // R5: free-running loop driven by a behavioural converter
    src_sel = 3'd0; tick("R5");
    manual_start = 1'b1; tick("R5");
    manual_start = 1'b0;
    nreq = (start_req === 1'b1) ? 1 : 0;
    cnt = (start_req === 1'b1) ? 4 : 0;
    done_pend = 1'b0;
    for (int c = 0; c < 80; c++) begin
      conv_busy = (cnt > 0);
      conv_done = done_pend;
      tick("R5");
      done_pend = 1'b0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) done_pend = 1'b1;
      end
      if (start_req === 1'b1) begin
        cnt = 4;
        nreq++;
      end
    end
    checks++;
    if (nreq < 10) begin
      errors++;
      $display("FAIL R5: restarts actual=%0d expected>=10", nreq);
    end
    conv_busy = 1'b0; conv_done = 1'b0; tick("R5");

    // Constrained random mix, checked per cycle (R9 R7 R10 R8)
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(7) == 0) src_sel = 3'($urandom_range(7));
      conv_enable  = ($urandom_range(9) != 0);
      auto_en      = ($urandom_range(5) != 0);
      conv_busy    = ($urandom_range(3) == 0);
      manual_start = ($urandom_range(7) == 0);
      for (int s = 0; s < 8; s++)
        if ($urandom_range(2) == 0) set_src(3'(s), 1'($urandom_range(1)));
      tick("R9");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule